// File: doc/BRIEF.md
# Interlocked Bus Read Requester

This block sits on the device side of an unclocked shared bus and fetches one data word from memory. It uses a fully interlocked handshake. A local request on `start_i` latches an address. The block then drives that address onto the bus and raises its read-request line. The rest of the transfer is paced entirely by the memory's edges. Each phase waits for the other party to move before making its own move.

The memory confirms the request on its acknowledge line. The requester answers by withdrawing the request and releasing the address lines. Once memory has lowered its acknowledge and raised data-ready, the requester takes the word from the bus and raises its own acknowledge. When data-ready falls, the requester lowers its acknowledge, and that closes the transfer.

Both incoming control lines reach the local clock domain through two-flop synchronizers. The local side sees a one-cycle completion strobe together with the captured word. A busy flag covers the whole exchange, and start requests made while it is high are ignored.

Top module: `hsr_requester`

## Requirements
- R1: While reset is asserted and right after it, `bus_req_o`, `bus_addr_oe_o`, `bus_ack_o`, `busy_o` and `done_o` are all 0.
- R2: A `start_i` pulse sampled while idle makes `bus_req_o`, `bus_addr_oe_o` and `busy_o` 1 at the next clock edge, with `bus_addr_o` equal to the `addr_i` sampled at that edge.
- R3: `bus_req_o` stays high until the memory acknowledge has been seen high. It then falls together with `bus_addr_oe_o`, and `bus_addr_o` returns to all zeros.
- R4: After the request has been withdrawn, `bus_ack_o` stays 0 for as long as data-ready stays low. The requester never drives request and acknowledge high at the same time.
- R5: Once data-ready has been seen high (after memory's acknowledge was seen low), the requester captures `bus_data_i` and raises `bus_ack_o`.
- R6: `bus_ack_o` stays high for as long as data-ready stays high. Changes on `bus_data_i` after the capture do not alter the word delivered.
- R7: When data-ready has been seen low, `bus_ack_o` falls and `done_o` is 1 for exactly one cycle in that same cycle, with `rdata_o` holding the captured word and `busy_o` already 0.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored: the bus address does not change and no second request follows the completion.
- R9: Each incoming control line passes through two synchronizer flops before the state machine acts on it. An edge on `bus_ack_i` or `bus_rdy_i` therefore changes the registered outputs at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one read when idle |
| addr_i | input | AW | Memory address for the read |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | DW | Word captured from the bus |
| bus_req_o | output | 1 | Read request toward memory |
| bus_addr_oe_o | output | 1 | Address lines driven by this block |
| bus_addr_o | output | AW | Address lines (zero when released) |
| bus_ack_i | input | 1 | Acknowledge from memory (asynchronous) |
| bus_rdy_i | input | 1 | Data-ready from memory (asynchronous) |
| bus_data_i | input | DW | Shared data lines |
| bus_ack_o | output | 1 | Acknowledge driven by the requester |

## Verification
The bound checker watches several rules on every cycle. Request and acknowledge are never high together. The address is enabled whenever the request is up, and it stays still while the request is held. The acknowledge rises only after synchronized data-ready was seen. The acknowledge holds while data-ready stays up. The completion strobe lasts one cycle and coincides with the acknowledge falling. Only the bench's scenarios can show the remaining behaviour: the three-edge synchronizer latency, the word captured despite bus data changing afterwards, the address taken from the start cycle, and a start during busy being dropped. The bench acts as the memory with varied acknowledge delays to exercise these.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_ACKLO = 3'd2,
        ST_WRDY  = 3'd3,
        ST_ACKD  = 3'd4
    } hsr_state_e;

endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] stage_d;
            if (g == 0) begin : g_first
                always_comb stage_d = async_i;
            end else begin : g_next
                always_comb stage_d = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d;
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsr_capture.sv
module hsr_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o
);
    logic [DW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) word_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign data_o = word_q;
endmodule

// File: rtl/hsr_requester.sv
module hsr_requester
    import hsr_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic          bus_req_o,
    output logic          bus_addr_oe_o,
    output logic [AW-1:0] bus_addr_o,
    input  logic          bus_ack_i,
    input  logic          bus_rdy_i,
    input  logic [DW-1:0] bus_data_i,
    output logic          bus_ack_o
);
    localparam int NCTL = 2;

    typedef struct packed {
        hsr_state_e    st;
        logic          req;
        logic          oe;
        logic          ack;
        logic          done;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NCTL-1:0] ctl_raw, ctl_sync;
    logic            ack_s, rdy_s;
    logic            cap_load;

    assign ctl_raw = {bus_rdy_i, bus_ack_i};

    hsr_sync #(.W(NCTL), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_raw),
        .sync_o  (ctl_sync)
    );

    assign ack_s = ctl_sync[0];
    assign rdy_s = ctl_sync[1];

    hsr_capture #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cap_load),
        .data_i (bus_data_i),
        .data_o (rdata_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        cap_load   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_REQ;
                    ctl_d.req  = 1'b1;
                    ctl_d.oe   = 1'b1;
                    ctl_d.addr = addr_i;
                end
            end
            ST_REQ: begin
                if (ack_s) begin
                    ctl_d.st  = ST_ACKLO;
                    ctl_d.req = 1'b0;
                    ctl_d.oe  = 1'b0;
                end
            end
            ST_ACKLO: begin
                if (!ack_s) ctl_d.st = ST_WRDY;
            end
            ST_WRDY: begin
                if (rdy_s) begin
                    cap_load  = 1'b1;
                    ctl_d.ack = 1'b1;
                    ctl_d.st  = ST_ACKD;
                end
            end
            ST_ACKD: begin
                if (!rdy_s) begin
                    ctl_d.ack  = 1'b0;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.req = 1'b0;
                ctl_d.oe  = 1'b0;
                ctl_d.ack = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, req: 1'b0, oe: 1'b0, ack: 1'b0,
                       done: 1'b0, addr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o        = (ctl_q.st != ST_IDLE);
    assign done_o        = ctl_q.done;
    assign bus_req_o     = ctl_q.req;
    assign bus_addr_oe_o = ctl_q.oe;
    assign bus_addr_o    = ctl_q.oe ? ctl_q.addr : '0;
    assign bus_ack_o     = ctl_q.ack;
endmodule

// File: rtl/hsr_requester_chk.sv
module hsr_requester_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          bus_req_o,
    input logic          bus_addr_oe_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          bus_ack_o,
    input logic          ack_s,
    input logic          rdy_s
);
    a_r2_oe_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> bus_addr_oe_o);

    a_r3_req_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !ack_s) |=> bus_req_o);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req_o && bus_ack_o));

    a_r5_ack_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack_o) |-> $past(rdy_s));

    a_r6_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack_o && rdy_s) |=> bus_ack_o);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_closes_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($fell(bus_ack_o) && !busy_o));

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && $past(bus_req_o)) |-> $stable(bus_addr_o));
endmodule

bind hsr_requester hsr_requester_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .bus_req_o     (bus_req_o),
    .bus_addr_oe_o (bus_addr_oe_o),
    .bus_addr_o    (bus_addr_o),
    .bus_ack_o     (bus_ack_o),
    .ack_s         (ack_s),
    .rdy_s         (rdy_s)
);

// File: tb/sim_hsr_requester.sv
module sim_hsr_requester;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NV = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          busy_o, done_o, bus_req_o, bus_addr_oe_o, bus_ack_o;
    logic [DW-1:0] rdata_o;
    logic [AW-1:0] bus_addr_o;
    logic          bus_ack_i = 1'b0;
    logic          bus_rdy_i = 1'b0;
    logic [DW-1:0] bus_data_i = '0;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    hsr_requester #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .bus_req_o(bus_req_o), .bus_addr_oe_o(bus_addr_oe_o),
        .bus_addr_o(bus_addr_o), .bus_ack_i(bus_ack_i),
        .bus_rdy_i(bus_rdy_i), .bus_data_i(bus_data_i),
        .bus_ack_o(bus_ack_o)
    );

    // {address, data word, memory acknowledge delay in cycles}
    localparam logic [71:0] VEC [NV] = '{
        {32'h0000_1000, 32'hDEAD_BEEF, 8'd0},
        {32'hFFFF_FFFC, 32'h0000_0000, 8'd3},
        {32'h1234_5678, 32'hFFFF_FFFF, 8'd7},
        {32'h0000_0004, 32'hA5A5_5A5A, 8'd1},
        {32'h8000_0000, 32'h0000_0001, 8'd12},
        {32'h0F0F_0F0F, 32'h8000_0000, 8'd2}
    };

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic run_xfer(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int dly, input bit poke_busy);
        int lat;
        @(negedge clk); start_i = 1'b1; addr_i = a;
        @(negedge clk); start_i = 1'b0; addr_i = ~a;
        chk(bus_req_o && bus_addr_oe_o && busy_o, "R2 req/oe/busy", {bus_req_o, bus_addr_oe_o, busy_o}, 3'b111);
        chk(bus_addr_o == a, "R2 address", bus_addr_o, a);
        if (poke_busy) begin
            start_i = 1'b1; addr_i = 32'h5555_AAAA;
            @(negedge clk); start_i = 1'b0;
            chk(bus_addr_o == a, "R8 address kept", bus_addr_o, a);
        end
        repeat (dly) @(negedge clk);
        chk(bus_req_o == 1'b1, "R3 req held", bus_req_o, 1'b1);
        bus_ack_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(bus_req_o == 1'b1, "R9 req after two edges", bus_req_o, 1'b1);
        @(negedge clk);
        chk(!bus_req_o && !bus_addr_oe_o && bus_addr_o == '0, "R3 req released",
            {bus_req_o, bus_addr_oe_o, bus_addr_o}, '0);
        bus_ack_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(bus_ack_o == 1'b0, "R4 no ack before rdy", bus_ack_o, 1'b0);
        bus_data_i = d; bus_rdy_i = 1'b1;
        lat = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (bus_ack_o) begin lat = k; break; end
        end
        chk(lat == 3, "R5 R9 ack latency", lat, 3);
        bus_data_i = ~d;
        repeat (5) @(negedge clk);
        chk(bus_ack_o == 1'b1, "R6 ack held", bus_ack_o, 1'b1);
        bus_rdy_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(bus_ack_o && !done_o, "R9 ack before sync", {bus_ack_o, done_o}, 2'b10);
        @(negedge clk);
        chk(!bus_ack_o && done_o && !busy_o, "R7 close", {bus_ack_o, done_o, busy_o}, 3'b010);
        chk(rdata_o == d, "R6 R7 word", rdata_o, d);
        @(negedge clk);
        chk(!done_o, "R7 one cycle", done_o, 1'b0);
        repeat (4) @(negedge clk);
        chk(!bus_req_o && !busy_o, "R8 no second request", {bus_req_o, busy_o}, 2'b00);
        chk(rdata_o == d, "R7 word held", rdata_o, d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=timeout expected=complete");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req_o && !bus_addr_oe_o && !bus_ack_o && !busy_o && !done_o,
            "R1 in reset", {bus_req_o, bus_addr_oe_o, bus_ack_o, busy_o, done_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req_o && !busy_o && !done_o, "R1 after reset",
            {bus_req_o, busy_o, done_o}, '0);

        for (int i = 0; i < NV; i++) begin
            run_xfer(VEC[i][71:40], VEC[i][39:8], int'(VEC[i][7:0]), (i == 2));
        end

        // Reset in the middle of a request.
        @(negedge clk); start_i = 1'b1; addr_i = 32'hCAFE_0000;
        @(negedge clk); start_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!bus_req_o && !busy_o && !bus_ack_o, "R1 mid-transfer reset",
            {bus_req_o, busy_o, bus_ack_o}, '0);
        rst_n = 1'b1;
        run_xfer(32'h0000_0040, 32'h1357_9BDF, 0, 1'b0);

        summary();
        $finish;
    end
endmodule